// File: doc/BRIEF.md
# Table-Jump Fetch Sequencer

This block carries out the two compressed table-jump instructions once the front end has decoded them. It takes the 8-bit table index, the PC of the 16-bit instruction, the configured table base and mode, the current XLEN, and a flag that says whether the current privilege level may use table jumps. From these it forms the address of one table entry and reads it through a simple request/response port. The read either returns the jump target or reports a fault.

On success the sequencer produces a one-cycle redirect to the fetched target. When the index selects the linking form, the same cycle also carries a write of the return address into `ra` and a push request for a return-address stack. On any failure it produces a one-cycle trap record instead. The trap record holds the cause, the instruction's own PC and the trap value. Failures are a denied permission, a mode value other than zero, or a faulting table read. The controller walks five named states.

- **IDLE**: waiting for an instruction.
- **REQ**: the read request is held.
- **WAIT**: waiting for the read response.
- **DONE**: the redirect pulse.
- **TRAP**: the trap pulse.

The transitions are:

- IDLE goes to REQ when it accepts a permitted mode-zero instruction, and to TRAP when it accepts any other instruction.
- REQ goes to WAIT on request ready.
- WAIT goes to DONE on a clean response and to TRAP on a faulting one.
- DONE and TRAP both return to IDLE unconditionally.

Top module: `tbl_jump_seq`

## Requirements
- R1: An index of 32 or more is the linking form: its success cycle raises `link_we_o` and `ras_push_o` together with the redirect, with `link_rd_o` = 1 and `link_data_o` = PC + 2 (kept to the low 32 bits and zero-extended when XLEN is 32). An index below 32 redirects with both of those outputs low.
- R2: The read address is the table base with its low 6 bits cleared, plus the index shifted left by 3 when `xlen64_i` = 1. When `xlen64_i` = 0 the index is shifted left by 2 and the sum is kept to its low 32 bits, zero-extended.
- R3: The redirect target is the returned entry with bit 0 cleared. When XLEN is 32, only bits 31:0 of the response are used and the upper target bits are zero.
- R4: When permission is granted but the mode is not 000000, the sequencer issues no read request and traps with cause 2, EPC equal to the instruction PC and trap value 0.
- R5: When `allow_i` = 0, the sequencer issues no read request and traps with EPC equal to the PC and trap value 0. The cause is 22 when `virt_i` = 1 and 2 otherwise. This check takes precedence over the mode check.
- R6: A response with `mrsp_fault_i` = 1 traps with cause 12 if `mrsp_pgfault_i` = 1 and cause 1 otherwise. The EPC is the table-jump PC and the trap value is the read address.
- R7: Any trap outcome keeps the redirect, the link write and the return-stack push all low.
- R8: `busy_o` is high from the cycle after acceptance through the outcome cycle. While busy, `start_i` and all instruction inputs are ignored.
- R9: Once raised, `mreq_valid_o` stays high with an unchanged `mreq_addr_o` until `mreq_ready_i` is seen.
- R10: After reset the sequencer is idle, with `busy_o`, `mreq_valid_o`, `redir_valid_o`, `link_we_o`, `ras_push_o` and `trap_valid_o` all low.
- R11: Each accepted instruction produces exactly one single-cycle pulse of either `redir_valid_o` or `trap_valid_o`, and the sequencer is idle in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Decoded table-jump instruction is present (taken only when idle) |
| index_i | input | 8 | Table index field |
| pc_i | input | 64 | PC of the table-jump instruction |
| base_i | input | 64 | Table base address (low 6 bits ignored) |
| mode_i | input | 6 | Table mode, only 0 is implemented |
| xlen64_i | input | 1 | 1 = XLEN 64, 0 = XLEN 32 |
| allow_i | input | 1 | State-enable permission for the current privilege level |
| virt_i | input | 1 | Denied access reports a virtual-instruction trap |
| busy_o | output | 1 | An instruction is in progress |
| mreq_valid_o | output | 1 | Table read request |
| mreq_ready_i | input | 1 | Request accepted by memory |
| mreq_addr_o | output | 64 | Table entry address |
| mrsp_valid_i | input | 1 | Read response present |
| mrsp_data_i | input | 64 | Table entry data |
| mrsp_fault_i | input | 1 | Response carries a fault |
| mrsp_pgfault_i | input | 1 | Fault is a page fault (else access fault) |
| redir_valid_o | output | 1 | Redirect pulse |
| redir_pc_o | output | 64 | Redirect target |
| link_we_o | output | 1 | Link register write |
| link_rd_o | output | 5 | Link destination register number (ra) |
| link_data_o | output | 64 | Return address |
| ras_push_o | output | 1 | Return-address stack push |
| trap_valid_o | output | 1 | Trap pulse |
| trap_cause_o | output | 5 | Trap cause code |
| trap_epc_o | output | 64 | Trap EPC |
| trap_tval_o | output | 64 | Trap value |

## Verification
The per-cycle properties cover several behaviours:

- the request handshake holding its address steady;
- the link write and the stack push always travelling together and only alongside a redirect;
- traps never carrying a link, push or redirect;
- outcome pulses lasting a single cycle;
- a disallowed instruction going straight to a trap without a request;
- a faulting response always leading to a trap.

The arithmetic cannot be shown by those properties and rests on the bench scenarios:

- the scaled entry address and its 32-bit wrap;
- the bit-0 clearing and truncation of the target;
- the PC + 2 link value;
- the exact cause codes, the precedence of permission over mode, and the insensitivity to inputs that change while busy.

// File: rtl/tjs_pkg.sv
package tjs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_REQ  = 3'd1,
        ST_WAIT = 3'd2,
        ST_DONE = 3'd3,
        ST_TRAP = 3'd4
    } tjs_state_e;

    localparam int CAUSE_W = 5;

    localparam logic [CAUSE_W-1:0] CAUSE_FETCH_ACCESS = 5'd1;
    localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL      = 5'd2;
    localparam logic [CAUSE_W-1:0] CAUSE_FETCH_PAGE   = 5'd12;
    localparam logic [CAUSE_W-1:0] CAUSE_VIRTUAL      = 5'd22;

    localparam logic [4:0] RA_REG = 5'd1;

endpackage

// File: rtl/tjs_addr_gen.sv
// Entry address: aligned base plus index scaled by the entry size.
module tjs_addr_gen #(
    parameter int AW       = 64,
    parameter int IW       = 8,
    parameter int ALIGN_LG = 6
) (
    input  logic [AW-1:0] base_i,
    input  logic [IW-1:0] idx_i,
    input  logic          x64_i,
    output logic [AW-1:0] addr_o
);
    localparam logic [AW-1:0] ALIGN_MASK = ~AW'((64'd1 << ALIGN_LG) - 64'd1);

    logic [AW-1:0] base_al;
    logic [AW-1:0] offs;
    logic [AW-1:0] sum;

    always_comb begin
        base_al = base_i & ALIGN_MASK;
        offs    = x64_i ? (AW'(idx_i) << 3) : (AW'(idx_i) << 2);
        sum     = base_al + offs;
        addr_o  = x64_i ? sum : AW'(sum[31:0]);
    end
endmodule

// File: rtl/tjs_fsm.sv
module tjs_fsm
    import tjs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       legal_i,
    input  logic       req_ready_i,
    input  logic       rsp_valid_i,
    input  logic       rsp_fault_i,
    output tjs_state_e state_o,
    output logic       accept_o,
    output logic       take_rsp_o,
    output logic       busy_o,
    output logic       req_valid_o,
    output logic       done_o,
    output logic       trap_o
);
    tjs_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i)     state_d = legal_i ? ST_REQ : ST_TRAP;
            ST_REQ:  if (req_ready_i) state_d = ST_WAIT;
            ST_WAIT: if (rsp_valid_i) state_d = rsp_fault_i ? ST_TRAP : ST_DONE;
            ST_DONE:                  state_d = ST_IDLE;
            ST_TRAP:                  state_d = ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        accept_o    = 1'b0;
        take_rsp_o  = 1'b0;
        busy_o      = 1'b1;
        req_valid_o = 1'b0;
        done_o      = 1'b0;
        trap_o      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin busy_o = 1'b0; accept_o = start_i; end
            ST_REQ:  req_valid_o = 1'b1;
            ST_WAIT: take_rsp_o = rsp_valid_i;
            ST_DONE: done_o = 1'b1;
            ST_TRAP: trap_o = 1'b1;
            default: busy_o = 1'b0;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/tjs_capture.sv
// Holds the accepted instruction and the response-derived results.
module tjs_capture
    import tjs_pkg::*;
#(
    parameter int AW       = 64,
    parameter int IW       = 8,
    parameter int LINK_IDX = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               accept_i,
    input  logic               take_rsp_i,
    input  logic [IW-1:0]      idx_i,
    input  logic [AW-1:0]      pc_i,
    input  logic               x64_i,
    input  logic               allow_i,
    input  logic               virt_i,
    input  logic [AW-1:0]      addr_i,
    input  logic [AW-1:0]      rsp_data_i,
    input  logic               rsp_fault_i,
    input  logic               rsp_pgfault_i,
    output logic [AW-1:0]      addr_o,
    output logic [AW-1:0]      target_o,
    output logic [AW-1:0]      link_o,
    output logic               is_link_o,
    output logic [CAUSE_W-1:0] cause_o,
    output logic [AW-1:0]      tval_o,
    output logic [AW-1:0]      epc_o
);
    logic               x64_q;
    logic [AW-1:0]      link_full;
    logic [AW-1:0]      entry;
    logic [CAUSE_W-1:0] deny_cause;

    always_comb begin
        link_full  = pc_i + AW'(2);
        entry      = x64_q ? rsp_data_i : AW'(rsp_data_i[31:0]);
        deny_cause = (!allow_i && virt_i) ? CAUSE_VIRTUAL : CAUSE_ILLEGAL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x64_q     <= 1'b0;
            addr_o    <= '0;
            target_o  <= '0;
            link_o    <= '0;
            is_link_o <= 1'b0;
            cause_o   <= '0;
            tval_o    <= '0;
            epc_o     <= '0;
        end else if (accept_i) begin
            x64_q     <= x64_i;
            addr_o    <= addr_i;
            link_o    <= x64_i ? link_full : AW'(link_full[31:0]);
            is_link_o <= (idx_i >= IW'(LINK_IDX));
            cause_o   <= deny_cause;
            tval_o    <= '0;
            epc_o     <= pc_i;
        end else if (take_rsp_i) begin
            if (rsp_fault_i) begin
                cause_o <= rsp_pgfault_i ? CAUSE_FETCH_PAGE : CAUSE_FETCH_ACCESS;
                tval_o  <= addr_o;
            end else begin
                target_o <= {entry[AW-1:1], 1'b0};
            end
        end
    end
endmodule

// File: rtl/tbl_jump_seq.sv
module tbl_jump_seq
    import tjs_pkg::*;
#(
    parameter int AW       = 64,
    parameter int IW       = 8,
    parameter int MODE_W   = 6,
    parameter int LINK_IDX = 32,
    parameter int ALIGN_LG = 6,
    parameter bit RV64_EN  = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [IW-1:0]      index_i,
    input  logic [AW-1:0]      pc_i,
    input  logic [AW-1:0]      base_i,
    input  logic [MODE_W-1:0]  mode_i,
    input  logic               xlen64_i,
    input  logic               allow_i,
    input  logic               virt_i,
    output logic               busy_o,
    output logic               mreq_valid_o,
    input  logic               mreq_ready_i,
    output logic [AW-1:0]      mreq_addr_o,
    input  logic               mrsp_valid_i,
    input  logic [AW-1:0]      mrsp_data_i,
    input  logic               mrsp_fault_i,
    input  logic               mrsp_pgfault_i,
    output logic               redir_valid_o,
    output logic [AW-1:0]      redir_pc_o,
    output logic               link_we_o,
    output logic [4:0]         link_rd_o,
    output logic [AW-1:0]      link_data_o,
    output logic               ras_push_o,
    output logic               trap_valid_o,
    output logic [CAUSE_W-1:0] trap_cause_o,
    output logic [AW-1:0]      trap_epc_o,
    output logic [AW-1:0]      trap_tval_o
);
    logic          x64_eff;
    logic          legal;
    logic [AW-1:0] addr_calc;
    tjs_state_e    state;
    logic          accept, take_rsp, done, trap, is_link;

    generate
        if (RV64_EN) begin : g_rv64
            assign x64_eff = xlen64_i;
        end else begin : g_rv32
            logic unused_x64;
            assign unused_x64 = xlen64_i;
            assign x64_eff    = 1'b0;
        end
    endgenerate

    assign legal = allow_i && (mode_i == '0);

    tjs_addr_gen #(.AW(AW), .IW(IW), .ALIGN_LG(ALIGN_LG)) addr_i (
        .base_i (base_i),
        .idx_i  (index_i),
        .x64_i  (x64_eff),
        .addr_o (addr_calc)
    );

    tjs_fsm fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .legal_i     (legal),
        .req_ready_i (mreq_ready_i),
        .rsp_valid_i (mrsp_valid_i),
        .rsp_fault_i (mrsp_fault_i),
        .state_o     (state),
        .accept_o    (accept),
        .take_rsp_o  (take_rsp),
        .busy_o      (busy_o),
        .req_valid_o (mreq_valid_o),
        .done_o      (done),
        .trap_o      (trap)
    );

    tjs_capture #(.AW(AW), .IW(IW), .LINK_IDX(LINK_IDX)) cap_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .accept_i      (accept),
        .take_rsp_i    (take_rsp),
        .idx_i         (index_i),
        .pc_i          (pc_i),
        .x64_i         (x64_eff),
        .allow_i       (allow_i),
        .virt_i        (virt_i),
        .addr_i        (addr_calc),
        .rsp_data_i    (mrsp_data_i),
        .rsp_fault_i   (mrsp_fault_i),
        .rsp_pgfault_i (mrsp_pgfault_i),
        .addr_o        (mreq_addr_o),
        .target_o      (redir_pc_o),
        .link_o        (link_data_o),
        .is_link_o     (is_link),
        .cause_o       (trap_cause_o),
        .tval_o        (trap_tval_o),
        .epc_o         (trap_epc_o)
    );

    logic unused_state;
    assign unused_state = ^state;

    always_comb begin
        redir_valid_o = done;
        link_we_o     = done && is_link;
        ras_push_o    = done && is_link;
        trap_valid_o  = trap;
        link_rd_o     = RA_REG;
    end
endmodule

// File: rtl/tjs_checker.sv
module tjs_checker #(
    parameter int AW     = 64,
    parameter int MODE_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [MODE_W-1:0] mode_i,
    input logic              allow_i,
    input logic              busy_o,
    input logic              mreq_valid_o,
    input logic              mreq_ready_i,
    input logic [AW-1:0]     mreq_addr_o,
    input logic              mrsp_valid_i,
    input logic              mrsp_fault_i,
    input logic              redir_valid_o,
    input logic              link_we_o,
    input logic              ras_push_o,
    input logic              trap_valid_o
);
    logic waiting;
    assign waiting = busy_o && !mreq_valid_o && !redir_valid_o && !trap_valid_o;

    a_r9_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mreq_valid_o && !mreq_ready_i) |=> (mreq_valid_o && $stable(mreq_addr_o)));

    a_r1_link_with_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        link_we_o |-> (ras_push_o && redir_valid_o));

    a_r1_push_with_link: assert property (@(posedge clk) disable iff (!rst_n)
        ras_push_o |-> link_we_o);

    a_r7_trap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid_o |-> (!redir_valid_o && !link_we_o && !ras_push_o));

    a_r8_req_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mreq_valid_o |-> busy_o);

    a_r4_no_fetch_when_barred: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && (!allow_i || mode_i != '0)) |=> (trap_valid_o && !mreq_valid_o));

    a_r6_fault_traps: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && mrsp_valid_i && mrsp_fault_i) |=> trap_valid_o);

    a_r11_redir_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid_o |=> (!redir_valid_o && !busy_o));

    a_r11_trap_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid_o |=> (!trap_valid_o && !busy_o));
endmodule

bind tbl_jump_seq tjs_checker #(.AW(AW), .MODE_W(MODE_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .mode_i        (mode_i),
    .allow_i       (allow_i),
    .busy_o        (busy_o),
    .mreq_valid_o  (mreq_valid_o),
    .mreq_ready_i  (mreq_ready_i),
    .mreq_addr_o   (mreq_addr_o),
    .mrsp_valid_i  (mrsp_valid_i),
    .mrsp_fault_i  (mrsp_fault_i),
    .redir_valid_o (redir_valid_o),
    .link_we_o     (link_we_o),
    .ras_push_o    (ras_push_o),
    .trap_valid_o  (trap_valid_o)
);

// File: tb/tbl_jump_seq_tb_top.sv
`timescale 1ns/1ps
module tbl_jump_seq_tb_top;

    typedef struct packed {
        logic [7:0]  idx;
        logic [63:0] pc;
        logic [63:0] base;
        logic        x64;
        logic [5:0]  mode;
        logic        allow;
        logic        virt;
        logic        fault;
        logic        pg;
        logic [1:0]  stall;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{8'd0,   64'h1000,        64'h8000_0000,   1'b1, 6'd0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0},
        '{8'd31,  64'h2002,        64'h4000_0040,   1'b0, 6'd0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0},
        '{8'd32,  64'h3000,        64'h4000_0000,   1'b0, 6'd0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd1},
        '{8'd255, 64'h1_2345_6788, 64'h7_0000_0000, 1'b1, 6'd0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd2},
        '{8'd20,  64'hFFFF_FFFE,   64'hFFFF_FFC0,   1'b0, 6'd0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0},
        '{8'd1,   64'h5554,        64'h1000_003F,   1'b1, 6'd0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0},
        '{8'd40,  64'h6000,        64'h2000_0000,   1'b1, 6'd1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0},
        '{8'd2,   64'h7000,        64'h2000_0000,   1'b1, 6'd3, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0},
        '{8'd50,  64'h7100,        64'h2000_0000,   1'b0, 6'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0},
        '{8'd33,  64'h8000,        64'h9000_0000,   1'b1, 6'd0, 1'b1, 1'b0, 1'b1, 1'b0, 2'd1},
        '{8'd7,   64'h8800,        64'h9000_0100,   1'b0, 6'd0, 1'b1, 1'b0, 1'b1, 1'b1, 2'd0},
        '{8'd200, 64'hA000,        64'h3_0000_0000, 1'b1, 6'd0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [7:0]  index_i = '0;
    logic [63:0] pc_i = '0;
    logic [63:0] base_i = '0;
    logic [5:0]  mode_i = '0;
    logic        xlen64_i = 1'b0;
    logic        allow_i = 1'b0;
    logic        virt_i = 1'b0;
    logic        busy_o;
    logic        mreq_valid_o;
    logic        mreq_ready_i = 1'b0;
    logic [63:0] mreq_addr_o;
    logic        mrsp_valid_i = 1'b0;
    logic [63:0] mrsp_data_i = '0;
    logic        mrsp_fault_i = 1'b0;
    logic        mrsp_pgfault_i = 1'b0;
    logic        redir_valid_o;
    logic [63:0] redir_pc_o;
    logic        link_we_o;
    logic [4:0]  link_rd_o;
    logic [63:0] link_data_o;
    logic        ras_push_o;
    logic        trap_valid_o;
    logic [4:0]  trap_cause_o;
    logic [63:0] trap_epc_o;
    logic [63:0] trap_tval_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    tbl_jump_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .index_i(index_i), .pc_i(pc_i),
        .base_i(base_i), .mode_i(mode_i), .xlen64_i(xlen64_i), .allow_i(allow_i),
        .virt_i(virt_i), .busy_o(busy_o), .mreq_valid_o(mreq_valid_o),
        .mreq_ready_i(mreq_ready_i), .mreq_addr_o(mreq_addr_o),
        .mrsp_valid_i(mrsp_valid_i), .mrsp_data_i(mrsp_data_i),
        .mrsp_fault_i(mrsp_fault_i), .mrsp_pgfault_i(mrsp_pgfault_i),
        .redir_valid_o(redir_valid_o), .redir_pc_o(redir_pc_o), .link_we_o(link_we_o),
        .link_rd_o(link_rd_o), .link_data_o(link_data_o), .ras_push_o(ras_push_o),
        .trap_valid_o(trap_valid_o), .trap_cause_o(trap_cause_o),
        .trap_epc_o(trap_epc_o), .trap_tval_o(trap_tval_o)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] memword(input logic [63:0] a);
        return {~a[31:0], a[31:0] ^ 32'h1357_9BDF};
    endfunction

    function automatic logic [63:0] exp_addr(input vec_t v);
        logic [63:0] s;
        s = (v.base & ~64'h3F) + (v.x64 ? (64'(v.idx) << 3) : (64'(v.idx) << 2));
        return v.x64 ? s : {32'h0, s[31:0]};
    endfunction

    task automatic run_vec(input vec_t v, input bit hold);
        int          phase = 0;
        int          stall = int'(v.stall);
        int          nreq = 0;
        bit          got = 0;
        logic [63:0] seen = '0;
        logic        r_v = 0, r_l = 0, r_p = 0, t_v = 0;
        logic [63:0] r_pc = '0, r_ld = '0, t_epc = '0, t_tval = '0;
        logic [4:0]  t_c = '0, r_rd = '0;
        logic [63:0] w, ea, exp_tgt, exp_link;
        bit          fetch;
        logic [4:0]  ecause;

        @(negedge clk);
        start_i = 1'b1; index_i = v.idx; pc_i = v.pc; base_i = v.base; mode_i = v.mode;
        xlen64_i = v.x64; allow_i = v.allow; virt_i = v.virt;
        for (int k = 0; k < 40 && !got; k++) begin
            @(negedge clk);
            if (!hold) start_i = 1'b0;
            else begin index_i = ~v.idx; pc_i = ~v.pc; base_i = ~v.base; end
            if (redir_valid_o || trap_valid_o) begin
                got = 1;
                r_v = redir_valid_o; r_l = link_we_o; r_p = ras_push_o; r_pc = redir_pc_o;
                r_ld = link_data_o; r_rd = link_rd_o; t_v = trap_valid_o; t_c = trap_cause_o;
                t_epc = trap_epc_o; t_tval = trap_tval_o;
                chk(busy_o, "R8 busy at outcome", 64'(busy_o), 64'd1);
                mrsp_valid_i = 1'b0; mrsp_fault_i = 1'b0; mrsp_pgfault_i = 1'b0;
                start_i = 1'b0;
            end else begin
                chk(busy_o, "R8 busy in flight", 64'(busy_o), 64'd1);
                if (phase == 1) begin
                    mreq_ready_i = 1'b0; mrsp_valid_i = 1'b1; mrsp_data_i = memword(seen);
                    mrsp_fault_i = v.fault; mrsp_pgfault_i = v.pg; phase = 2;
                end else if (phase == 0 && mreq_valid_o) begin
                    if (nreq == 0) begin nreq = 1; seen = mreq_addr_o; end
                    else chk(mreq_addr_o == seen, "R9 address held", mreq_addr_o, seen);
                    if (stall == 0) begin mreq_ready_i = 1'b1; phase = 1; end
                    else stall--;
                end
            end
        end
        mreq_ready_i = 1'b0;
        chk(got, "R11 outcome produced", 64'(got), 64'd1);

        fetch = v.allow && (v.mode == 0);
        ea = exp_addr(v);
        w = memword(ea);
        exp_tgt = v.x64 ? (w & ~64'd1) : {32'h0, w[31:1], 1'b0};
        exp_link = v.x64 ? (v.pc + 64'd2) : {32'h0, v.pc[31:0] + 32'd2};

        if (!fetch) begin
            ecause = !v.allow ? (v.virt ? 5'd22 : 5'd2) : 5'd2;
            if (!v.allow) begin
                chk(nreq == 0, "R5 no request", 64'(nreq), 64'd0);
                chk(t_v && t_c == ecause, "R5 cause", 64'(t_c), 64'(ecause));
                chk(t_epc == v.pc && t_tval == 0, "R5 epc/tval", t_epc, v.pc);
            end else begin
                chk(nreq == 0, "R4 no request", 64'(nreq), 64'd0);
                chk(t_v && t_c == ecause, "R4 cause", 64'(t_c), 64'(ecause));
                chk(t_epc == v.pc && t_tval == 0, "R4 epc/tval", t_epc, v.pc);
            end
            chk(!r_v && !r_l && !r_p, "R7 no redirect on trap", {61'd0, r_v, r_l, r_p}, 64'd0);
        end else begin
            chk(nreq == 1 && seen == ea, "R2 entry address", seen, ea);
            if (v.fault) begin
                ecause = v.pg ? 5'd12 : 5'd1;
                chk(t_v && t_c == ecause, "R6 fault cause", 64'(t_c), 64'(ecause));
                chk(t_tval == ea, "R6 tval", t_tval, ea);
                chk(t_epc == v.pc, "R6 epc", t_epc, v.pc);
                chk(!r_v && !r_l && !r_p, "R7 no link on trap", {61'd0, r_v, r_l, r_p}, 64'd0);
            end else begin
                chk(r_v && !t_v, "R11 redirect only", {62'd0, r_v, t_v}, 64'd2);
                chk(r_pc == exp_tgt, "R3 target", r_pc, exp_tgt);
                if (v.idx >= 8'd32) begin
                    chk(r_l && r_p && r_rd == 5'd1, "R1 link+push", {59'd0, r_rd, r_l, r_p}, {59'd0, 5'd1, 2'b11});
                    chk(r_ld == exp_link, "R1 link value", r_ld, exp_link);
                end else begin
                    chk(!r_l && !r_p, "R1 plain no link", {62'd0, r_l, r_p}, 64'd0);
                end
            end
        end
        @(negedge clk);
        chk(!busy_o && !redir_valid_o && !trap_valid_o && !mreq_valid_o, "R11 idle after pulse",
            {60'd0, busy_o, redir_valid_o, trap_valid_o, mreq_valid_o}, 64'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL R11 watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(!busy_o && !mreq_valid_o && !redir_valid_o && !link_we_o && !ras_push_o && !trap_valid_o,
            "R10 reset outputs",
            {58'd0, busy_o, mreq_valid_o, redir_valid_o, link_we_o, ras_push_o, trap_valid_o}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o, "R10 idle after release", 64'(busy_o), 64'd0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i], 1'b0);

        // R8: start and inputs changed while busy are ignored
        run_vec('{8'd45, 64'hC0DE, 64'h5_0000_0000, 1'b1, 6'd0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd2}, 1'b1);
        run_vec('{8'd3, 64'h4444, 64'h6000_0000, 1'b0, 6'd0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0}, 1'b1);

        // R10: reset during a transaction returns to idle
        @(negedge clk);
        start_i = 1'b1; index_i = 8'd4; allow_i = 1'b1; mode_i = '0;
        @(negedge clk);
        start_i = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        chk(!busy_o && !mreq_valid_o, "R10 mid-run reset", {62'd0, busy_o, mreq_valid_o}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule